// File: doc/BRIEF.md
# Status-Coded Two-Wire Byte Master

This block is a single-master two-wire (I2C) controller that works one byte at a time. A host programs it through a small write port and reads three registers as plain outputs: control, data and status. Every bus step is started by a control-register write. The steps are START, repeated START, address byte, data byte out, data byte in and STOP. When a step other than STOP completes, the block raises a pending flag and posts an 8-bit code that names the bus state reached. The host inspects the code, loads the data register if needed, and then writes control with the flag bit clear. That write both acknowledges the flag and launches the next step.

The bus is driven open-drain. Each of `scl_oe_o` and `sda_oe_o` pulls its line low when high. The line levels come back on `scl_i` and `sda_i`. Bit timing comes from `tick_i`: one tick is a quarter of an SCL period, and a high phase waits for `scl_i` to read high so that a target can stretch the clock. Only 7-bit addressing is supported. Bit 0 of the address byte selects read (1) or write (0). A missing acknowledge is reported through its own status code.

Top module: `i2c_status_master`

## Requirements
- R1: After `rst_ni` is released, `status_o` reads 0xF8, `ctrl_o` and `data_o` read 0x00, `irq_o` is 0, and neither line is pulled.
- R2: Control bits are IEN=7, EN=6, START=5, STOP=4, FLAG=3 and ACK=2. START and STOP always read back 0. From idle, a control write with START=1 and EN=1 produces status 0x08 and a raised FLAG, with SCL and SDA both held low. The same write with EN=0 is ignored.
- R3: While FLAG is raised inside a transfer, a control write with START=1, FLAG=0 and EN=1 performs a repeated START and ends with status 0x10.
- R4: The first byte sent after a START or repeated START is an address. Its outcome is reported as follows:
  - write address (bit 0 = 0): 0x18 when acknowledged, 0x20 when not;
  - read address (bit 0 = 1): 0x40 when acknowledged, 0x48 when not.
- R5: A data byte sent in write direction ends with 0x28 when acknowledged and 0x30 when not.
- R6: After a read address that was acknowledged, each launch receives one byte into `data_o`. When ACK=1 at launch, the block returns an acknowledge (SDA low in the ninth bit) and the status is 0x50. When ACK=0 it returns no acknowledge and the status is 0x58.
- R7: A control write with FLAG=0 and EN=1 while FLAG is raised clears FLAG on the next cycle and launches the next step. A control write with FLAG=1 leaves FLAG raised and the status unchanged.
- R8: A STOP (STOP=1, FLAG=0, EN=1 while FLAG is raised) never raises FLAG. When both lines are released, the status becomes 0xF8. A START written while the STOP is still in progress is ignored.
- R9: Writes to offset 1 (data) are ignored while FLAG is low and are taken while it is high.
- R10: `irq_o` is high exactly when FLAG and IEN are both set.
- R11: Any write to offset 2 returns the block to its reset state on the next cycle, even in mid-transfer, and a new START from idle then works. Offset 0 is control and offset 3 is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Quarter-SCL-period step enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register offset: 0 control, 1 data, 2 soft reset |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| data_o | output | 8 | Data register readback |
| status_o | output | 8 | Bus status code |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
Two events can meet in one cycle: a host control write, and the bus engine finishing or still running a step. The sharpest case is a START written while a STOP is still releasing the lines. The bench issues the STOP and then writes START on the very next cycle. It then requires that no flag is ever seen, that the status settles at 0xF8, and that a later START from true idle still reports 0x08. A data-register write while the flag is low is also checked against an idle bus, so that it cannot be confused with a receive completing in the same cycle.

// File: rtl/i2c_status_master_pkg.sv
package i2c_status_master_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] OFS_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] OFS_DATA = 2'd1;
  localparam logic [REG_AW-1:0] OFS_SRST = 2'd2;

  // control bit positions, decoded by host software
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [BYTE_W-1:0] SC_START    = 8'h08;
  localparam logic [BYTE_W-1:0] SC_RSTART   = 8'h10;
  localparam logic [BYTE_W-1:0] SC_AW_ACK   = 8'h18;
  localparam logic [BYTE_W-1:0] SC_AW_NAK   = 8'h20;
  localparam logic [BYTE_W-1:0] SC_DW_ACK   = 8'h28;
  localparam logic [BYTE_W-1:0] SC_DW_NAK   = 8'h30;
  localparam logic [BYTE_W-1:0] SC_AR_ACK   = 8'h40;
  localparam logic [BYTE_W-1:0] SC_AR_NAK   = 8'h48;
  localparam logic [BYTE_W-1:0] SC_DR_ACK   = 8'h50;
  localparam logic [BYTE_W-1:0] SC_DR_NAK   = 8'h58;
  localparam logic [BYTE_W-1:0] SC_IDLE     = 8'hF8;

  typedef enum logic [2:0] {
    CMD_START,
    CMD_RSTART,
    CMD_STOP,
    CMD_WRITE,
    CMD_READ
  } bus_cmd_e;
endpackage

// File: rtl/i2csm_phy.sv
module i2csm_phy
  import i2c_status_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  bus_cmd_e          cmd_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              ack_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              ack_rx_o,
  output logic              busy_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int BIT_CW = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {PS_IDLE, PS_HOLD, PS_START, PS_RSTART, PS_STOP, PS_BIT} phy_state_e;

  phy_state_e        state_q;
  logic [1:0]        step_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rd_q, ack_q, scl_oe_q, sda_oe_q, done_q, ack_rx_q;
  logic              last_bit;

  assign last_bit = (bit_q == BIT_CW'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE; step_q <= '0; bit_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; ack_q <= 1'b0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
      done_q <= 1'b0; ack_rx_q <= 1'b0;
    end else if (srst_i) begin
      state_q <= PS_IDLE; step_q <= '0; bit_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; ack_q <= 1'b0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
      done_q <= 1'b0; ack_rx_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PS_IDLE, PS_HOLD: begin
          if (cmd_valid_i) begin
            step_q <= '0;
            unique case (cmd_i)
              CMD_START:  state_q <= PS_START;
              CMD_RSTART: state_q <= PS_RSTART;
              CMD_STOP:   state_q <= PS_STOP;
              default: begin
                state_q <= PS_BIT;
                bit_q   <= '0;
                rd_q    <= (cmd_i == CMD_READ);
                sh_q    <= (cmd_i == CMD_READ) ? '1 : tx_i;
                ack_q   <= ack_i;
              end
            endcase
          end
        end
        PS_START: if (tick_i) begin
          if (step_q == 2'd0) begin
            sda_oe_q <= 1'b1; step_q <= 2'd1;
          end else begin
            scl_oe_q <= 1'b1; done_q <= 1'b1; state_q <= PS_HOLD;
          end
        end
        PS_RSTART: if (tick_i) begin
          unique case (step_q)
            2'd0: begin sda_oe_q <= 1'b0; step_q <= 2'd1; end
            2'd1: begin scl_oe_q <= 1'b0; step_q <= 2'd2; end
            2'd2: if (scl_i) begin sda_oe_q <= 1'b1; step_q <= 2'd3; end
            default: begin scl_oe_q <= 1'b1; done_q <= 1'b1; state_q <= PS_HOLD; end
          endcase
        end
        PS_STOP: if (tick_i) begin
          unique case (step_q)
            2'd0: begin sda_oe_q <= 1'b1; step_q <= 2'd1; end
            2'd1: begin scl_oe_q <= 1'b0; step_q <= 2'd2; end
            default: if (scl_i) begin
              sda_oe_q <= 1'b0; done_q <= 1'b1; state_q <= PS_IDLE;
            end
          endcase
        end
        default: if (tick_i) begin
          unique case (step_q)
            2'd0: begin
              // ninth bit: receiver drives its ACK; data bits: sender drives
              sda_oe_q <= last_bit ? (rd_q & ack_q) : (!rd_q & !sh_q[BYTE_W-1]);
              step_q   <= 2'd1;
            end
            2'd1: begin scl_oe_q <= 1'b0; step_q <= 2'd2; end
            2'd2: if (scl_i) begin
              if (last_bit) ack_rx_q <= !sda_i;
              else          sh_q     <= {sh_q[BYTE_W-2:0], sda_i};
              step_q <= 2'd3;
            end
            default: begin
              scl_oe_q <= 1'b1;
              step_q   <= 2'd0;
              if (last_bit) begin
                done_q <= 1'b1; state_q <= PS_HOLD;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end

  assign done_o   = done_q;
  assign rx_o     = sh_q;
  assign ack_rx_o = ack_rx_q;
  assign busy_o   = (state_q != PS_IDLE) && (state_q != PS_HOLD);
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2csm_regs.sv
module i2csm_regs
  import i2c_status_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              phy_done_i,
  input  logic              phy_busy_i,
  input  logic [BYTE_W-1:0] phy_rx_i,
  input  logic              phy_ack_rx_i,
  output logic              cmd_valid_o,
  output bus_cmd_e          cmd_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic              ack_cmd_o,
  output logic              srst_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              irq_o
);
  logic              ack_en_q, en_q, ien_q, flag_q;
  logic              in_txn_q, addr_next_q, rd_mode_q, ack_sent_q;
  logic [BYTE_W-1:0] status_q, data_q;
  bus_cmd_e          last_cmd_q;
  logic              ctrl_wr, launch;
  bus_cmd_e          cmd;

  assign ctrl_wr = wr_en_i && (wr_addr_i == OFS_CTRL);
  assign srst_o  = wr_en_i && (wr_addr_i == OFS_SRST);

  always_comb begin
    launch = 1'b0;
    cmd    = CMD_START;
    if (ctrl_wr && wr_data_i[CB_EN] && !phy_busy_i) begin
      if (!in_txn_q && wr_data_i[CB_START]) begin
        launch = 1'b1;
      end else if (in_txn_q && flag_q && !wr_data_i[CB_FLAG]) begin
        launch = 1'b1;
        if (wr_data_i[CB_START])     cmd = CMD_RSTART;
        else if (wr_data_i[CB_STOP]) cmd = CMD_STOP;
        else if (rd_mode_q)          cmd = CMD_READ;
        else                         cmd = CMD_WRITE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_en_q <= 1'b0; en_q <= 1'b0; ien_q <= 1'b0; flag_q <= 1'b0;
      in_txn_q <= 1'b0; addr_next_q <= 1'b0; rd_mode_q <= 1'b0; ack_sent_q <= 1'b0;
      status_q <= SC_IDLE; data_q <= '0; last_cmd_q <= CMD_START;
    end else if (srst_o) begin
      ack_en_q <= 1'b0; en_q <= 1'b0; ien_q <= 1'b0; flag_q <= 1'b0;
      in_txn_q <= 1'b0; addr_next_q <= 1'b0; rd_mode_q <= 1'b0; ack_sent_q <= 1'b0;
      status_q <= SC_IDLE; data_q <= '0; last_cmd_q <= CMD_START;
    end else begin
      if (ctrl_wr) begin
        ack_en_q <= wr_data_i[CB_ACK];
        en_q     <= wr_data_i[CB_EN];
        ien_q    <= wr_data_i[CB_IEN];
      end
      if (launch) begin
        flag_q     <= 1'b0;
        last_cmd_q <= cmd;
        ack_sent_q <= wr_data_i[CB_ACK];
      end
      if (wr_en_i && (wr_addr_i == OFS_DATA) && flag_q) data_q <= wr_data_i;
      if (phy_done_i) begin
        unique case (last_cmd_q)
          CMD_START, CMD_RSTART: begin
            status_q    <= (last_cmd_q == CMD_START) ? SC_START : SC_RSTART;
            flag_q      <= 1'b1;
            in_txn_q    <= 1'b1;
            addr_next_q <= 1'b1;
            rd_mode_q   <= 1'b0;
          end
          CMD_WRITE: begin
            flag_q <= 1'b1;
            if (addr_next_q) begin
              addr_next_q <= 1'b0;
              rd_mode_q   <= data_q[0] & phy_ack_rx_i;
              if (data_q[0]) status_q <= phy_ack_rx_i ? SC_AR_ACK : SC_AR_NAK;
              else           status_q <= phy_ack_rx_i ? SC_AW_ACK : SC_AW_NAK;
            end else begin
              status_q <= phy_ack_rx_i ? SC_DW_ACK : SC_DW_NAK;
            end
          end
          CMD_READ: begin
            flag_q   <= 1'b1;
            data_q   <= phy_rx_i;
            status_q <= ack_sent_q ? SC_DR_ACK : SC_DR_NAK;
          end
          default: begin
            status_q    <= SC_IDLE;
            in_txn_q    <= 1'b0;
            addr_next_q <= 1'b0;
            rd_mode_q   <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cmd_valid_o = launch;
  assign cmd_o       = cmd;
  assign tx_o        = data_q;
  assign ack_cmd_o   = wr_data_i[CB_ACK];
  assign ctrl_o      = {ien_q, en_q, 2'b00, flag_q, ack_en_q, 2'b00};
  assign data_o      = data_q;
  assign status_o    = status_q;
  assign irq_o       = flag_q & ien_q;
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2c_status_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              irq_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic              cmd_valid, srst, ack_cmd, phy_done, phy_busy, phy_ack_rx;
  bus_cmd_e          cmd;
  logic [BYTE_W-1:0] tx, phy_rx;

  i2csm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .phy_done_i   (phy_done),
    .phy_busy_i   (phy_busy),
    .phy_rx_i     (phy_rx),
    .phy_ack_rx_i (phy_ack_rx),
    .cmd_valid_o  (cmd_valid),
    .cmd_o        (cmd),
    .tx_o         (tx),
    .ack_cmd_o    (ack_cmd),
    .srst_o       (srst),
    .ctrl_o, .data_o, .status_o, .irq_o
  );

  i2csm_phy u_phy (
    .clk_i, .rst_ni,
    .srst_i      (srst),
    .tick_i,
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .tx_i        (tx),
    .ack_i       (ack_cmd),
    .scl_i, .sda_i,
    .done_o      (phy_done),
    .rx_o        (phy_rx),
    .ack_rx_o    (phy_ack_rx),
    .busy_o      (phy_busy),
    .scl_oe_o, .sda_oe_o
  );
endmodule

// File: rtl/i2c_status_master_chk.sv
module i2c_status_master_chk
  import i2c_status_master_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic [BYTE_W-1:0] ctrl_o,
  input logic [BYTE_W-1:0] data_o,
  input logic [BYTE_W-1:0] status_o,
  input logic              irq_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o
);
  assert_cmd_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[CB_START] == 1'b0 && ctrl_o[CB_STOP] == 1'b0);

  assert_start_lines_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CB_FLAG] && status_o == SC_START) |-> (scl_oe_o && sda_oe_o));

  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_CTRL && ctrl_o[CB_FLAG] && !wr_data_i[CB_FLAG] && wr_data_i[CB_EN])
    |=> !ctrl_o[CB_FLAG]);

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_CTRL && ctrl_o[CB_FLAG] && wr_data_i[CB_FLAG])
    |=> (ctrl_o[CB_FLAG] && $stable(status_o)));

  assert_idle_no_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == SC_IDLE) |-> !ctrl_o[CB_FLAG]);

  assert_data_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_DATA && !ctrl_o[CB_FLAG] && status_o == SC_IDLE)
    |=> $stable(data_o));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_o[CB_FLAG] && ctrl_o[CB_IEN]));

  assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_SRST)
    |=> (status_o == SC_IDLE && ctrl_o == '0 && !scl_oe_o && !sda_oe_o));
endmodule

bind i2c_status_master i2c_status_master_chk u_chk (.*);

// File: tb/i2c_status_master_bench.sv
`timescale 1ns/1ps
module i2c_status_master_bench;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] ctrl, data, status;
  wire        irq, scl_oe, sda_oe;
  logic       s_low = 1'b0;
  wire        scl = ~scl_oe;
  wire        sda = ~(sda_oe | s_low);

  int checks = 0, errors = 0;
  bit exp_ien = 1'b0, model_on = 1'b0, nak_data = 1'b0;
  int tcnt = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  i2c_status_master u_i2c_status_master (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .data_o(data), .status_o(status), .irq_o(irq),
    .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // behavioural target at 7-bit address 0x2A
  function automatic logic [7:0] rb(int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  int b = 0, rd_idx = 0;
  bit just = 0, is_addr = 0, sel = 0, rd = 0, sending = 0, m_ack = 0;
  logic [7:0] shift = '0, tx = '0, last_rx = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  always begin
    @(scl or sda);
    if (scl_p && scl && sda_p && !sda) begin
      just = 1; is_addr = 1; sel = 0; sending = 0; s_low = 0; b = 0;
    end else if (scl_p && scl && !sda_p && sda) begin
      sel = 0; sending = 0;
    end else if (!scl_p && scl) begin
      if (b < 8) shift = {shift[6:0], sda};
      else       m_ack = !sda;
    end else if (scl_p && !scl) begin
      if (just) begin
        just = 0; b = 0;
      end else begin
        b++;
        if (b == 8) begin
          if (is_addr) begin
            sel = (shift[7:1] == 7'h2A); rd = shift[0]; s_low = sel;
          end else if (sel && !rd) begin
            last_rx = shift; s_low = !nak_data;
          end else s_low = 0;
        end else if (b == 9) begin
          b = 0; s_low = 0;
          sending = sel && rd && (is_addr || (sending && m_ack));
          is_addr = 0;
          if (sending) begin
            tx = rb(rd_idx); rd_idx++; s_low = !tx[7];
          end
        end else if (sending) begin
          s_low = !tx[7-b];
        end
      end
    end
    scl_p = scl; sda_p = sda;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock model of the interrupt output
  always @(posedge clk) begin
    #1;
    if (model_on) begin
      checks++;
      if (irq !== (exp_ien & ctrl[3])) begin
        errors++;
        $display("FAIL R10: irq actual %b expected %b", irq, exp_ien & ctrl[3]);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd0) exp_ien = d[7];
    if (a == 2'd2) exp_ien = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(string req, logic [7:0] code);
    int n = 0;
    while (!ctrl[3] && n < 3000) begin @(negedge clk); n++; end
    check(req, {7'd0, ctrl[3], status}, {8'h01, code});
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    bit saw = 0;
    while (status != 8'hF8 && n < 3000) begin
      @(negedge clk); n++;
      if (ctrl[3]) saw = 1;
    end
    check(req, {7'd0, saw, status}, {8'h00, 8'hF8});
    check(req, {14'd0, scl_oe, sda_oe}, 16'h0000);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", {8'd0, status}, 16'h00F8);
    check("R1 ctrl/data", {ctrl, data}, 16'h0000);
    check("R1 lines", {14'd0, irq, scl_oe | sda_oe}, 16'h0000);
    // R9 data write while flag low
    wr(2'd1, 8'h55);
    check("R9 ignored", {8'd0, data}, 16'h0000);
    // R2 START without EN ignored
    wr(2'd0, 8'h20);
    repeat (300) @(negedge clk);
    check("R2 no-en", {7'd0, ctrl[3], status}, 16'h00F8);
    // R2 START
    wr(2'd0, 8'hE0);
    wait_flag("R2 start", 8'h08);
    check("R2 ctrl readback", {8'd0, ctrl}, 16'h00C8);
    check("R2 lines low", {14'd0, scl_oe, sda_oe}, 16'h0003);
    check("R10 irq", {15'd0, irq}, 16'h0001);
    // R9 data taken while flag high
    wr(2'd1, 8'h54);
    check("R9 taken", {8'd0, data}, 16'h0054);
    // R7 write with FLAG=1 holds
    wr(2'd0, 8'hC8);
    repeat (200) @(negedge clk);
    check("R7 hold", {7'd0, ctrl[3], status}, 16'h0108);
    // R7 clear and launch, R4 address write acked
    wr(2'd0, 8'hC0);
    check("R7 cleared", {15'd0, ctrl[3]}, 16'h0000);
    wait_flag("R4 aw ack", 8'h18);
    // R5 data acked and nacked
    wr(2'd1, 8'h3C); wr(2'd0, 8'hC0);
    wait_flag("R5 dw ack", 8'h28);
    check("R5 byte on bus", {8'd0, last_rx}, 16'h003C);
    nak_data = 1'b1;
    wr(2'd1, 8'h77); wr(2'd0, 8'hC0);
    wait_flag("R5 dw nak", 8'h30);
    nak_data = 1'b0;
    // R10 masked
    wr(2'd0, 8'h48);
    repeat (3) @(negedge clk);
    check("R10 masked", {15'd0, irq}, 16'h0000);
    wr(2'd0, 8'hC8);
    // R3 repeated START
    wr(2'd0, 8'hE0);
    wait_flag("R3 rstart", 8'h10);
    // R4 address read acked
    wr(2'd1, 8'h55); wr(2'd0, 8'hC0);
    wait_flag("R4 ar ack", 8'h40);
    // R6 receive with ACK then NAK
    wr(2'd0, 8'hC4);
    wait_flag("R6 rx ack", 8'h50);
    check("R6 byte0", {8'd0, data}, {8'd0, rb(0)});
    wr(2'd0, 8'hC0);
    wait_flag("R6 rx nak", 8'h58);
    check("R6 byte1", {8'd0, data}, {8'd0, rb(1)});
    // R8 STOP, with START written while it runs
    wr(2'd0, 8'hD0);
    check("R8 flag dropped", {15'd0, ctrl[3]}, 16'h0000);
    wr(2'd0, 8'hE0);
    wait_idle("R8 stop");
    repeat (300) @(negedge clk);
    check("R8 start ignored", {7'd0, ctrl[3], status}, 16'h00F8);
    // R4 read address not acked
    wr(2'd0, 8'hE0);
    wait_flag("R2 start again", 8'h08);
    wr(2'd1, 8'hA1); wr(2'd0, 8'hC0);
    wait_flag("R4 ar nak", 8'h48);
    // R4 write address not acked
    wr(2'd0, 8'hE0);
    wait_flag("R3 rstart2", 8'h10);
    wr(2'd1, 8'hA0); wr(2'd0, 8'hC0);
    wait_flag("R4 aw nak", 8'h20);
    // R11 soft reset mid-transfer
    wr(2'd2, 8'h00);
    check("R11 regs", {ctrl, status}, 16'h00F8);
    check("R11 data/lines", {data, 6'd0, scl_oe, sda_oe}, 16'h0000);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'hE0);
    wait_flag("R11 restart", 8'h08);
    wr(2'd0, 8'hD0);
    wait_idle("R8 final stop");
    finish_run();
  end
endmodule